// File: doc/BRIEF.md
# Multi-Frame HDLC Receive FIFO

This block buffers received HDLC frames of varying length between a line-side receiver and a host. All frames share one circular byte store. The line side presents one byte per cycle. A strobe marks the byte that closes a frame. The line side is never stalled and never sees a full indication.

Two frame counters track whole frames. The write counter counts closed frames and the read counter counts frames the host has released. A small table holds the end address of each closed frame, indexed by frame slot. A single read pointer holds the address of the last byte the host consumed. The host sees the remaining byte count of the oldest frame and whether that frame is exhausted. It can pop bytes, release the frame, and issue a refresh that reloads a one-byte read prefetch register. A reset command returns the FIFO to empty.

The host also sees the number of pending frames. An overrun of the frame counter or of the byte store sets a sticky overflow flag.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After `rst_n` is low, or after a cycle with `host_rst` high, the FIFO is empty. In that state `fifo_empty`=1, `frame_count`=0, `frame_len`=0, `frame_done`=0 and `overflow`=0. `host_rst` wins over a line write in the same cycle.
- R2: Every cycle with `wr_valid`=1 stores `wr_data` at the next byte address. No condition blocks the write. A cycle with `wr_valid`=1 and `wr_eof`=1 also closes the frame.
- R3: `frame_count` equals closed frames minus released frames, modulo 2^FRM_LOG2. A frame still being written is not counted, and its bytes are not visible. `frame_len` reads 0 while `frame_count` is 0.
- R4: While `frame_count`≠0, `frame_len` gives the bytes not yet popped from the oldest frame. It is that frame's stored end address minus the read pointer, modulo 2^DEPTH_LOG2. An accepted pop lowers it by one.
- R5: `rd_data` shows the prefetch register. Successive pops return the oldest frame's bytes in write order. A pop is ignored when `frame_count`=0 or `frame_done`=1.
- R6: `frame_done` is 1 exactly when `frame_count`≠0 and every byte of the oldest frame has been popped.
- R7: `host_next` releases the oldest frame only while `frame_done`=1. Released means `frame_count` drops by one, and the read pointer stays as the base of the next frame. Otherwise `host_next` is ignored.
- R8: `fifo_empty` is 1 exactly when `frame_count`=0 and no byte of an unfinished frame is buffered.
- R9: `host_sel` reloads `rd_data` with the byte after the read pointer. Line writes and frame releases never update the prefetch register, so `rd_data` can be stale until a refresh.
- R10: `overflow` is set in two cases. One is a write whose address lands on the read pointer. The other is a frame close that wraps `frame_count` to 0. The data is still stored. The flag stays set until R1 clears it.
- R11: Byte addresses wrap modulo 2^DEPTH_LOG2. Frames that straddle the wrap read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Line byte present this cycle |
| wr_data | input | 8 | Line byte |
| wr_eof | input | 1 | With wr_valid: byte closes the frame |
| host_sel | input | 1 | Refresh the read prefetch register |
| host_pop | input | 1 | Consume the byte shown on rd_data |
| host_next | input | 1 | Release the exhausted oldest frame |
| host_rst | input | 1 | Return the FIFO to empty |
| rd_data | output | 8 | Prefetch register contents |
| frame_len | output | DEPTH_LOG2 | Bytes left in the oldest frame |
| frame_count | output | FRM_LOG2 | Pending closed frames |
| frame_done | output | 1 | Oldest frame fully popped |
| fifo_empty | output | 1 | No frame and no partial data buffered |
| overflow | output | 1 | Sticky overrun flag |

## Verification
The hardest situation to reach is a frame that straddles the end of the byte store while other frames sit ahead of and behind it. The bench reaches it by sweeping frame lengths against frame counts in a 16-byte store, draining the FIFO fully between rounds. Because it never resets between rounds, the pointers drift and cross the wrap at many different offsets. The two overrun cases also need preparation from the ports. For the frame-count overrun the bench closes one frame more than the counter can hold. For the byte overrun it writes one byte more than the store holds in a single unfinished frame.

// File: rtl/hdlc_rx_fifo_pkg.sv
package hdlc_rx_fifo_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rx_byte_store.sv
module rx_byte_store
    import hdlc_rx_fifo_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  byte_t         wdata,
    input  logic [AW-1:0] raddr,
    output byte_t         rdata
);
    localparam int DEPTH = 1 << AW;

    byte_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rx_end_table.sv
module rx_end_table #(
    parameter int FW = 5,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [FW-1:0] wslot,
    input  logic [AW-1:0] wend,
    input  logic [FW-1:0] rslot,
    output logic [AW-1:0] rend
);
    localparam int SLOTS = 1 << FW;

    logic [AW-1:0] end_q [SLOTS];

    always_ff @(posedge clk) begin
        if (we) end_q[wslot] <= wend;
    end

    assign rend = end_q[rslot];
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rx_fifo_pkg::*;
#(
    parameter int DEPTH_LOG2 = 9,
    parameter int FRM_LOG2   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [7:0]            wr_data,
    input  logic                  wr_eof,
    input  logic                  host_sel,
    input  logic                  host_pop,
    input  logic                  host_next,
    input  logic                  host_rst,
    output logic [7:0]            rd_data,
    output logic [DEPTH_LOG2-1:0] frame_len,
    output logic [FRM_LOG2-1:0]   frame_count,
    output logic                  frame_done,
    output logic                  fifo_empty,
    output logic                  overflow
);
    localparam int AW = DEPTH_LOG2;
    localparam int FW = FRM_LOG2;
    localparam logic [AW-1:0] ONE_A = AW'(1);
    localparam logic [AW-1:0] TWO_A = AW'(2);
    localparam logic [FW-1:0] ONE_F = FW'(1);

    typedef struct packed {
        logic [FW-1:0] f_wr;   // closed-frame counter
        logic [FW-1:0] f_rd;   // released-frame counter
        logic [AW-1:0] wp;     // address of last written byte
        logic [AW-1:0] rp;     // address of last consumed byte
        byte_t         pref;   // read prefetch register
        logic          ovf;
    } state_t;

    state_t s_q, s_d;

    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] front_end;
    logic [FW-1:0] pending;
    logic [FW-1:0] f_wr_inc;
    logic          has_frame;
    logic          at_end;
    logic          pop_ok;
    logic          next_ok;
    logic          close_fire;
    byte_t         store_rdata;

    // Controller decode
    always_comb begin
        wr_addr    = s_q.wp + ONE_A;
        f_wr_inc   = s_q.f_wr + ONE_F;
        pending    = s_q.f_wr - s_q.f_rd;
        has_frame  = (pending != '0);
        at_end     = has_frame && (front_end == s_q.rp);
        pop_ok     = host_pop && has_frame && !at_end;
        next_ok    = host_next && at_end;
        close_fire = wr_valid && wr_eof;
        rd_addr    = pop_ok ? (s_q.rp + TWO_A) : (s_q.rp + ONE_A);
    end

    // Next-state computation
    always_comb begin
        s_d = s_q;
        if (host_rst) begin
            s_d = '0;
        end else begin
            if (wr_valid) begin
                s_d.wp = wr_addr;
                if (wr_addr == s_q.rp) s_d.ovf = 1'b1;
            end
            if (close_fire) begin
                s_d.f_wr = f_wr_inc;
                if (f_wr_inc == s_q.f_rd) s_d.ovf = 1'b1;
            end
            if (pop_ok) begin
                s_d.rp   = s_q.rp + ONE_A;
                s_d.pref = store_rdata;
            end else if (host_sel) begin
                s_d.pref = store_rdata;
            end
            if (next_ok) s_d.f_rd = s_q.f_rd + ONE_F;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    rx_byte_store #(.AW(AW)) u_store (
        .clk   (clk),
        .we    (wr_valid && !host_rst),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (store_rdata)
    );

    rx_end_table #(.FW(FW), .AW(AW)) u_ends (
        .clk   (clk),
        .we    (close_fire && !host_rst),
        .wslot (s_q.f_wr),
        .wend  (wr_addr),
        .rslot (s_q.f_rd),
        .rend  (front_end)
    );

    assign rd_data     = s_q.pref;
    assign frame_count = pending;
    assign frame_len   = has_frame ? (front_end - s_q.rp) : '0;
    assign frame_done  = at_end;
    assign fifo_empty  = !has_frame && (s_q.wp == s_q.rp);
    assign overflow    = s_q.ovf;
endmodule

// File: rtl/hdlc_rx_fifo_chk.sv
module hdlc_rx_fifo_chk #(
    parameter int AW = 9,
    parameter int FW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          wr_eof,
    input logic          host_sel,
    input logic          host_pop,
    input logic          host_next,
    input logic          host_rst,
    input logic [7:0]    rd_data,
    input logic [AW-1:0] frame_len,
    input logic [FW-1:0] frame_count,
    input logic          frame_done,
    input logic          fifo_empty,
    input logic          overflow
);
    // R1
    rst_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst |=> (fifo_empty && frame_count == '0 && !overflow));

    // R3
    idle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_count == '0) |-> (frame_len == '0 && !frame_done));

    // R4
    pop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && frame_count != '0 && !frame_done && !host_rst)
        |=> (frame_len == $past(frame_len) - 1'b1));

    // R7
    next_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_next && !frame_done && !host_rst && !(wr_valid && wr_eof))
        |=> (frame_count == $past(frame_count)));

    // R8
    empty_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> (frame_count == '0));

    // R9
    stale_pref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_sel && !host_pop && !host_rst) |=> $stable(rd_data));

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !host_rst) |=> overflow);
endmodule

bind hdlc_rx_fifo hdlc_rx_fifo_chk #(.AW(DEPTH_LOG2), .FW(FRM_LOG2)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_eof      (wr_eof),
    .host_sel    (host_sel),
    .host_pop    (host_pop),
    .host_next   (host_next),
    .host_rst    (host_rst),
    .rd_data     (rd_data),
    .frame_len   (frame_len),
    .frame_count (frame_count),
    .frame_done  (frame_done),
    .fifo_empty  (fifo_empty),
    .overflow    (overflow)
);

// File: tb/tb_hdlc_rx_fifo.sv
module tb_hdlc_rx_fifo;
    localparam int AW = 4;
    localparam int FW = 3;
    localparam int CAP = (1 << AW) - 1;
    localparam int MAXF = (1 << FW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          wr_eof = 1'b0;
    logic          host_sel = 1'b0;
    logic          host_pop = 1'b0;
    logic          host_next = 1'b0;
    logic          host_rst = 1'b0;
    logic [7:0]    rd_data;
    logic [AW-1:0] frame_len;
    logic [FW-1:0] frame_count;
    logic          frame_done;
    logic          fifo_empty;
    logic          overflow;

    int n_checks = 0;
    int n_fail = 0;
    int wr_ctr = 0;
    int rd_ctr = 0;

    always #10 clk = ~clk;

    hdlc_rx_fifo #(.DEPTH_LOG2(AW), .FRM_LOG2(FW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_eof(wr_eof), .host_sel(host_sel), .host_pop(host_pop),
        .host_next(host_next), .host_rst(host_rst), .rd_data(rd_data),
        .frame_len(frame_len), .frame_count(frame_count),
        .frame_done(frame_done), .fifo_empty(fifo_empty), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // One-cycle stimulus; returns at the next falling edge, after the update
    task automatic wr(input int d, input bit eof);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d[7:0]; wr_eof = eof;
        @(negedge clk);
        wr_valid = 1'b0; wr_eof = 1'b0;
    endtask

    task automatic pulse_sel();
        @(negedge clk); host_sel = 1'b1;
        @(negedge clk); host_sel = 1'b0;
    endtask

    task automatic pulse_pop();
        @(negedge clk); host_pop = 1'b1;
        @(negedge clk); host_pop = 1'b0;
    endtask

    task automatic pulse_next();
        @(negedge clk); host_next = 1'b1;
        @(negedge clk); host_next = 1'b0;
    endtask

    task automatic pulse_rst(input bit with_write);
        @(negedge clk);
        host_rst = 1'b1;
        wr_valid = with_write; wr_eof = with_write; wr_data = 8'h3C;
        @(negedge clk);
        host_rst = 1'b0; wr_valid = 1'b0; wr_eof = 1'b0;
    endtask

    task automatic write_frame(input int len);
        for (int b = 0; b < len; b++) begin
            wr(wr_ctr & 8'hFF, b == len - 1);
            wr_ctr++;
        end
    endtask

    task automatic drain_frame(input int len, input int cnt_before);
        chk_eq("R4 front length", int'(frame_len), len);
        pulse_next();   // not exhausted yet: ignored
        chk_eq("R7 early release ignored", int'(frame_count), cnt_before);
        pulse_sel();
        for (int b = 0; b < len; b++) begin
            chk_eq("R5 byte order", int'(rd_data), rd_ctr & 8'hFF);
            pulse_pop();
            rd_ctr++;
            chk_eq("R4 length after pop", int'(frame_len), len - b - 1);
        end
        chk_eq("R6 frame done", int'(frame_done), 1);
        pulse_pop();    // extra pop: ignored
        chk_eq("R5 extra pop ignored", int'(frame_len), 0);
        chk_eq("R6 still done", int'(frame_done), 1);
        pulse_next();
        chk_eq("R7 release", int'(frame_count), (cnt_before - 1) & MAXF);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        int prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 empty", int'(fifo_empty), 1);
        chk_eq("R1 count", int'(frame_count), 0);
        chk_eq("R1 len", int'(frame_len), 0);
        chk_eq("R1 done", int'(frame_done), 0);
        chk_eq("R1 ovf", int'(overflow), 0);

        // R2 R4 R5 R6 R7 R8 R11: sweep lengths and counts, pointers drift across the wrap
        for (int len = 1; len <= 5; len++) begin
            for (int nf = 1; nf <= 3; nf++) begin
                if (len * nf <= CAP) begin
                    for (int k = 0; k < nf; k++) write_frame(len);
                    chk_eq("R2 frames closed", int'(frame_count), nf);
                    chk_eq("R8 not empty", int'(fifo_empty), 0);
                    for (int k = 0; k < nf; k++) drain_frame(len, nf - k);
                    chk_eq("R8 drained empty", int'(fifo_empty), 1);
                    chk_eq("R10 no overflow R11 wrap", int'(overflow), 0);
                end
            end
        end

        // R9 stale prefetch until refresh
        prev = int'(rd_data);
        wr(8'hA5, 1'b1);
        chk_eq("R9 stale after write", int'(rd_data), prev);
        pulse_sel();
        chk_eq("R9 refreshed", int'(rd_data), 8'hA5);
        pulse_pop();
        pulse_next();
        chk_eq("R9 release empty", int'(fifo_empty), 1);

        // R3 unfinished frame invisible
        wr(8'h11, 1'b0);
        wr(8'h22, 1'b0);
        chk_eq("R3 partial count", int'(frame_count), 0);
        chk_eq("R3 partial len", int'(frame_len), 0);
        chk_eq("R8 partial not empty", int'(fifo_empty), 0);
        pulse_pop();
        chk_eq("R5 pop with no frame ignored", int'(fifo_empty), 0);
        wr(8'h33, 1'b1);
        chk_eq("R3 closed count", int'(frame_count), 1);
        chk_eq("R4 closed len", int'(frame_len), 3);
        pulse_sel();
        chk_eq("R5 first byte", int'(rd_data), 8'h11);
        pulse_pop();
        chk_eq("R5 second byte", int'(rd_data), 8'h22);
        pulse_pop();
        chk_eq("R5 third byte", int'(rd_data), 8'h33);
        pulse_pop();
        pulse_next();
        chk_eq("R8 empty again", int'(fifo_empty), 1);

        // R10 frame-count overrun
        pulse_rst(1'b0);
        chk_eq("R1 host reset empty", int'(fifo_empty), 1);
        for (int k = 0; k < MAXF; k++) wr(k, 1'b1);
        chk_eq("R3 full count", int'(frame_count), MAXF);
        chk_eq("R10 no ovf at limit", int'(overflow), 0);
        wr(8'h77, 1'b1);
        chk_eq("R3 count wraps", int'(frame_count), 0);
        chk_eq("R10 count overrun", int'(overflow), 1);
        repeat (3) @(negedge clk);
        chk_eq("R10 sticky", int'(overflow), 1);
        pulse_rst(1'b1);
        chk_eq("R1 reset beats write empty", int'(fifo_empty), 1);
        chk_eq("R1 reset clears ovf", int'(overflow), 0);
        chk_eq("R1 reset count", int'(frame_count), 0);

        // R10 byte overrun
        for (int k = 0; k < CAP; k++) wr(k, 1'b0);
        chk_eq("R10 no ovf at capacity", int'(overflow), 0);
        wr(8'h99, 1'b0);
        chk_eq("R10 byte overrun", int'(overflow), 1);
        pulse_rst(1'b0);
        chk_eq("R1 final reset", int'(overflow), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule